// File: doc/BRIEF.md
# OTP Word Programming Pulse Engine

This block runs the program phase of a one-time-programmable memory controller. Software places one programming request in a single-entry buffer: a 32-bit data word first, then a 10-bit word address. The address write launches the request, provided program mode is active. Until the engine has taken the request, both buffer registers refuse further writes.

Once it has captured a request, the engine raises a program-enable strobe and waits a setup interval. It then fires one timed pulse for every bit of the word that is 1, starting at the least significant bit. A fixed gap separates consecutive pulses. After the last pulse the strobe is held for a hold interval, and a recovery interval follows. Pulses go to the normal array, the redundancy array, or to both. When both are selected, the normal array is done first and the same pulse train is then repeated for the redundancy array.

Every interval is given as a count of microsecond ticks minus one. The ticks come from a shared tick input. The array select is sampled only when program mode is entered.

Top module: `otp_prog_engine`

## Requirements
- R1: While `buf_empty` is 1, a data write and an address write each store their value, and the stored values are visible on `buf_data` and `buf_addr`. While `buf_empty` is 0, both writes are ignored and the stored values hold.
- R2: An address write made while `prog_mode` is 0 stores the address but launches nothing: `buf_empty` stays 1, `prog_ready` stays 1 and `pgm_en` stays 0.
- R3: Reset state: `buf_empty`=1, `prog_ready`=1, `pgm_en`=0 and both pulse outputs are 0. When an address write launches a request on an idle engine, `buf_empty` is 0 for exactly one cycle and then returns to 1. `prog_ready` falls in that same cycle and stays 0 until recovery ends.
- R4: `pgm_en` is high for `t_setup`+1 ticks before the first pulse.
- R5: Each bit that is 1 in the word gets exactly one pulse, in ascending bit order. During the pulse, `prog_bit` shows the bit index and `prog_addr` shows the word address. Each pulse lasts `t_width`+1 ticks.
- R6: Consecutive pulses are separated by `t_gap`+1 ticks with `pgm_en` high. This includes the step from the normal pass to the redundancy pass.
- R7: After the last pulse, `pgm_en` stays high for `t_hold`+1 ticks. It then stays low for `t_recov`+1 ticks before `prog_ready` returns to 1.
- R8: Array select encoding: 0 sends the full pulse train to the normal array (`pulse_norm`) and then to the redundancy array (`pulse_red`). 1 selects normal only, 2 selects redundancy only, and 3 (reserved) gives no pulses.
- R9: `arr_sel` is latched on the rising edge of `prog_mode`. Changing it while program mode stays on does not affect later requests.
- R10: An all-zero word gives no pulses: `pgm_en` stays high for `t_setup`+`t_hold`+2 ticks, and then recovery follows.
- R11: Interval counters advance only on cycles where `us_tick` is 1, so each interval length is counted in ticks regardless of how far apart the ticks are.
- R12: A request written while the engine is still busy waits in the buffer. It starts after the running request's recovery ends, with no pulse lost or merged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_mode | input | 1 | Program mode active |
| arr_sel | input | 2 | Target array select (0 both, 1 normal, 2 redundancy, 3 reserved) |
| us_tick | input | 1 | One-cycle microsecond tick |
| t_setup | input | 5 | Setup interval, ticks minus one |
| t_width | input | 5 | Pulse width, ticks minus one |
| t_gap | input | 3 | Inter-pulse gap, ticks minus one |
| t_hold | input | 5 | Hold interval, ticks minus one |
| t_recov | input | 7 | Recovery interval, ticks minus one |
| wr_data_en | input | 1 | Data word write strobe |
| wr_data | input | 32 | Data word to program |
| wr_addr_en | input | 1 | Word address write strobe (launches the request) |
| wr_addr | input | 10 | Word address |
| buf_empty | output | 1 | Buffer can take a new request |
| prog_ready | output | 1 | Engine idle |
| buf_data | output | 32 | Stored data word |
| buf_addr | output | 10 | Stored word address |
| pgm_en | output | 1 | Program enable to the cell |
| pulse_norm | output | 1 | Programming pulse, normal array |
| pulse_red | output | 1 | Programming pulse, redundancy array |
| prog_addr | output | 10 | Word address of the running request |
| prog_bit | output | 5 | Bit index being pulsed |

## Verification
The bench builds the block with its default widths, a 32-bit word and 10-bit address. It sets the timing fields to small values and mostly issues a tick on every cycle. With those settings even the heaviest case fits into a short run: an all-ones word sent to both arrays, which gives 64 pulses. A monitor counts ticks per interval, so one directed run with a tick on every third cycle can show that the counters advance only on ticks. Short fields also make it possible to reach the one-tick boundary (field value 0) for the gap, hold and recovery intervals.

// File: rtl/otp_prog_pkg.sv
package otp_prog_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_PULSE = 3'd2,
    ST_GAP   = 3'd3,
    ST_HOLD  = 3'd4,
    ST_RECOV = 3'd5
  } eng_state_t;

  localparam logic [1:0] SEL_BOTH = 2'd0;
  localparam logic [1:0] SEL_NORM = 2'd1;
  localparam logic [1:0] SEL_RED  = 2'd2;
  localparam logic [1:0] SEL_RSVD = 2'd3;

endpackage

// File: rtl/otp_pbuf.sv
module otp_pbuf #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prog_mode,
  input  logic              wr_data_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_addr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              take,
  output logic              empty,
  output logic [DATA_W-1:0] data_q,
  output logic [ADDR_W-1:0] addr_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      empty  <= 1'b1;
      data_q <= '0;
      addr_q <= '0;
    end else if (empty) begin
      if (wr_data_en) data_q <= wr_data;
      if (wr_addr_en) begin
        addr_q <= wr_addr;
        if (prog_mode) empty <= 1'b0;
      end
    end else if (take) begin
      empty <= 1'b1;
    end
  end

  // R1: contents frozen while a request is pending
  a_r1_locked: assert property (@(posedge clk) disable iff (rst)
    !empty |=> ($stable(data_q) && $stable(addr_q)));

  // R2: address write outside program mode launches nothing
  a_r2_no_launch: assert property (@(posedge clk) disable iff (rst)
    (empty && wr_addr_en && !prog_mode) |=> empty);

endmodule

// File: rtl/otp_tick_timer.sv
module otp_tick_timer #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                       cnt <= '0;
    else if (load)                 cnt <= load_val;
    else if (tick && cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign done = tick && (cnt == '0);

  // R11: the count moves only on a tick
  a_r11_tick_only: assert property (@(posedge clk) disable iff (rst)
    (!load && !tick) |=> $stable(cnt));

endmodule

// File: rtl/otp_pulse_seq.sv
module otp_pulse_seq
  import otp_prog_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 10,
  parameter int CNT_W   = 7,
  parameter int SETUP_W = 5,
  parameter int WIDTH_W = 5,
  parameter int GAP_W   = 3,
  parameter int HOLD_W  = 5,
  parameter int RECOV_W = 7,
  localparam int BIT_W  = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               prog_mode,
  input  logic [1:0]         arr_sel,
  input  logic               req,
  input  logic [DATA_W-1:0]  req_data,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [SETUP_W-1:0] t_setup,
  input  logic [WIDTH_W-1:0] t_width,
  input  logic [GAP_W-1:0]   t_gap,
  input  logic [HOLD_W-1:0]  t_hold,
  input  logic [RECOV_W-1:0] t_recov,
  input  logic               tmr_done,
  output logic               tmr_load,
  output logic [CNT_W-1:0]   tmr_val,
  output logic               take,
  output logic               prog_ready,
  output logic               pgm_en,
  output logic               pulse_norm,
  output logic               pulse_red,
  output logic [ADDR_W-1:0]  prog_addr,
  output logic [BIT_W-1:0]   prog_bit
);

  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  eng_state_t        state, nxt;
  logic              pass_red, both_left, pm_q;
  logic [1:0]        sel_eff;
  logic [DATA_W-1:0] work, keep, rem;
  logic [BIT_W-1:0]  cur_bit;
  logic [ADDR_W-1:0] cur_addr;

  function automatic logic [BIT_W-1:0] lowest_set(input logic [DATA_W-1:0] v);
    logic [BIT_W-1:0] idx;
    idx = '0;
    for (int i = DATA_W - 1; i >= 0; i--)
      if (v[i]) idx = BIT_W'(i);
    return idx;
  endfunction

  assign rem = work & ~(ONE << cur_bit);

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    take     = 1'b0;
    case (state)
      ST_IDLE: if (req) begin
        nxt = ST_SETUP; tmr_load = 1'b1; tmr_val = CNT_W'(t_setup); take = 1'b1;
      end
      ST_SETUP: if (tmr_done) begin
        tmr_load = 1'b1;
        if (work != '0) begin nxt = ST_PULSE; tmr_val = CNT_W'(t_width); end
        else            begin nxt = ST_HOLD;  tmr_val = CNT_W'(t_hold);  end
      end
      ST_PULSE: if (tmr_done) begin
        tmr_load = 1'b1;
        if (rem != '0 || (both_left && !pass_red)) begin
          nxt = ST_GAP; tmr_val = CNT_W'(t_gap);
        end else begin
          nxt = ST_HOLD; tmr_val = CNT_W'(t_hold);
        end
      end
      ST_GAP: if (tmr_done) begin
        nxt = ST_PULSE; tmr_load = 1'b1; tmr_val = CNT_W'(t_width);
      end
      ST_HOLD: if (tmr_done) begin
        nxt = ST_RECOV; tmr_load = 1'b1; tmr_val = CNT_W'(t_recov);
      end
      ST_RECOV: if (tmr_done) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      prog_ready <= 1'b1;
      pass_red   <= 1'b0;
      both_left  <= 1'b0;
      pm_q       <= 1'b0;
      sel_eff    <= SEL_BOTH;
      work       <= '0;
      keep       <= '0;
      cur_bit    <= '0;
      cur_addr   <= '0;
    end else begin
      state      <= nxt;
      prog_ready <= (nxt == ST_IDLE);
      pm_q       <= prog_mode;
      if (prog_mode && !pm_q) sel_eff <= arr_sel;
      case (state)
        ST_IDLE: if (req) begin
          keep      <= req_data;
          cur_addr  <= req_addr;
          work      <= (sel_eff == SEL_RSVD) ? '0 : req_data;
          pass_red  <= (sel_eff == SEL_RED);
          both_left <= (sel_eff == SEL_BOTH);
        end
        ST_SETUP: if (tmr_done && work != '0) cur_bit <= lowest_set(work);
        ST_PULSE: if (tmr_done) begin
          if (rem == '0 && both_left && !pass_red) begin
            work      <= keep;
            pass_red  <= 1'b1;
            both_left <= 1'b0;
          end else begin
            work <= rem;
          end
        end
        ST_GAP: if (tmr_done) cur_bit <= lowest_set(work);
        default: ;
      endcase
    end
  end

  assign pgm_en     = (state == ST_SETUP) || (state == ST_PULSE) ||
                      (state == ST_GAP)   || (state == ST_HOLD);
  assign pulse_norm = (state == ST_PULSE) && !pass_red;
  assign pulse_red  = (state == ST_PULSE) &&  pass_red;
  assign prog_addr  = cur_addr;
  assign prog_bit   = cur_bit;

  // R5: a pulse only ever targets a bit that is 1 in the captured word
  a_r5_bit_is_set: assert property (@(posedge clk) disable iff (rst)
    (pulse_norm || pulse_red) |-> keep[cur_bit]);

  // R3: engine never reports ready while the cell is enabled
  a_r3_busy_when_enabled: assert property (@(posedge clk) disable iff (rst)
    pgm_en |-> !prog_ready);

  // R7: dropping the enable leads into recovery, not straight to idle
  a_r7_recovery_follows: assert property (@(posedge clk) disable iff (rst)
    $fell(pgm_en) |-> !prog_ready);

  // R8: reserved select never produces a pulse
  a_r8_rsvd_silent: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && req && sel_eff == SEL_RSVD) |=> (work == '0));

endmodule

// File: rtl/otp_prog_engine.sv
module otp_prog_engine #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 10,
  parameter int SETUP_W = 5,
  parameter int WIDTH_W = 5,
  parameter int GAP_W   = 3,
  parameter int HOLD_W  = 5,
  parameter int RECOV_W = 7,
  localparam int BIT_W  = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               prog_mode,
  input  logic [1:0]         arr_sel,
  input  logic               us_tick,
  input  logic [SETUP_W-1:0] t_setup,
  input  logic [WIDTH_W-1:0] t_width,
  input  logic [GAP_W-1:0]   t_gap,
  input  logic [HOLD_W-1:0]  t_hold,
  input  logic [RECOV_W-1:0] t_recov,
  input  logic               wr_data_en,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               wr_addr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  output logic               buf_empty,
  output logic               prog_ready,
  output logic [DATA_W-1:0]  buf_data,
  output logic [ADDR_W-1:0]  buf_addr,
  output logic               pgm_en,
  output logic               pulse_norm,
  output logic               pulse_red,
  output logic [ADDR_W-1:0]  prog_addr,
  output logic [BIT_W-1:0]   prog_bit
);

  localparam int MAX_A = (SETUP_W > WIDTH_W) ? SETUP_W : WIDTH_W;
  localparam int MAX_B = (GAP_W > HOLD_W) ? GAP_W : HOLD_W;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = (MAX_C > RECOV_W) ? MAX_C : RECOV_W;

  logic             take, tmr_load, tmr_done;
  logic [CNT_W-1:0] tmr_val;

  otp_pbuf #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_pbuf (
    .clk(clk), .rst(rst), .prog_mode(prog_mode),
    .wr_data_en(wr_data_en), .wr_data(wr_data),
    .wr_addr_en(wr_addr_en), .wr_addr(wr_addr),
    .take(take), .empty(buf_empty), .data_q(buf_data), .addr_q(buf_addr)
  );

  otp_tick_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .tick(us_tick),
    .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  otp_pulse_seq #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .SETUP_W(SETUP_W), .WIDTH_W(WIDTH_W), .GAP_W(GAP_W),
    .HOLD_W(HOLD_W), .RECOV_W(RECOV_W)
  ) u_seq (
    .clk(clk), .rst(rst), .prog_mode(prog_mode), .arr_sel(arr_sel),
    .req(!buf_empty), .req_data(buf_data), .req_addr(buf_addr),
    .t_setup(t_setup), .t_width(t_width), .t_gap(t_gap),
    .t_hold(t_hold), .t_recov(t_recov),
    .tmr_done(tmr_done), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .take(take), .prog_ready(prog_ready), .pgm_en(pgm_en),
    .pulse_norm(pulse_norm), .pulse_red(pulse_red),
    .prog_addr(prog_addr), .prog_bit(prog_bit)
  );

endmodule

// File: tb/tb_otp_prog_engine.sv
module tb_otp_prog_engine;

  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst = 1'b1, prog_mode = 1'b0, us_tick = 1'b0;
  logic [1:0]  arr_sel = 2'd0;
  logic [4:0]  t_setup = 5'd2, t_width = 5'd3, t_hold = 5'd2;
  logic [2:0]  t_gap = 3'd1;
  logic [6:0]  t_recov = 7'd4;
  logic        wr_data_en = 1'b0, wr_addr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [9:0]  wr_addr = '0;
  logic        buf_empty, prog_ready, pgm_en, pulse_norm, pulse_red;
  logic [31:0] buf_data;
  logic [9:0]  buf_addr, prog_addr;
  logic [4:0]  prog_bit;
  int          tick_div = 1;
  int          n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  otp_prog_engine dut (
    .clk(clk), .rst(rst), .prog_mode(prog_mode), .arr_sel(arr_sel),
    .us_tick(us_tick), .t_setup(t_setup), .t_width(t_width), .t_gap(t_gap),
    .t_hold(t_hold), .t_recov(t_recov), .wr_data_en(wr_data_en),
    .wr_data(wr_data), .wr_addr_en(wr_addr_en), .wr_addr(wr_addr),
    .buf_empty(buf_empty), .prog_ready(prog_ready), .buf_data(buf_data),
    .buf_addr(buf_addr), .pgm_en(pgm_en), .pulse_norm(pulse_norm),
    .pulse_red(pulse_red), .prog_addr(prog_addr), .prog_bit(prog_bit)
  );

  // tick source
  initial begin
    int c;
    c = 0;
    forever begin
      @(posedge clk); #1;
      c = (c + 1 >= tick_div) ? 0 : c + 1;
      us_tick = (c == 0);
    end
  end

  // monitor: records pulses and tick counts per interval
  int   n_p, bits_q[128], w_min, w_max, g_min, g_max, setup_t, seg_t, hold_t, recov_t, cur_w;
  logic arr_q[128];
  logic [9:0] addr_seen;
  logic prev_pulse = 1'b0, prev_en = 1'b0;

  task automatic clear_mon();
    n_p = 0; w_min = 999; w_max = -1; g_min = 999; g_max = -1;
    setup_t = 0; seg_t = 0; hold_t = -1; recov_t = 0; cur_w = 0; addr_seen = '0;
  endtask

  always @(negedge clk) begin
    logic p;
    p = pulse_norm | pulse_red;
    if (p && !prev_pulse) begin
      if (n_p > 0) begin
        if (seg_t < g_min) g_min = seg_t;
        if (seg_t > g_max) g_max = seg_t;
      end
      if (n_p == 0) addr_seen = prog_addr;
      if (n_p < 128) begin bits_q[n_p] = int'(prog_bit); arr_q[n_p] = pulse_red; end
      n_p++; seg_t = 0; cur_w = 0;
    end
    if (!p && prev_pulse) begin
      if (cur_w < w_min) w_min = cur_w;
      if (cur_w > w_max) w_max = cur_w;
    end
    if (p) cur_w += int'(us_tick);
    if (pgm_en && !p) begin
      if (n_p == 0) setup_t += int'(us_tick);
      else          seg_t   += int'(us_tick);
    end
    if (!pgm_en && prev_en) hold_t = (n_p > 0) ? seg_t : setup_t;
    if (!pgm_en && !prog_ready) recov_t += int'(us_tick);
    prev_pulse = p;
    prev_en    = pgm_en;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_word(input logic [31:0] d, input logic [9:0] a);
    @(posedge clk); #1 wr_data_en = 1'b1; wr_data = d;
    @(posedge clk); #1 wr_data_en = 1'b0; wr_addr_en = 1'b1; wr_addr = a;
    @(posedge clk); #1 wr_addr_en = 1'b0;
  endtask

  task automatic enter_mode(input logic [1:0] s);
    @(posedge clk); #1 prog_mode = 1'b0; arr_sel = s;
    @(posedge clk); #1 prog_mode = 1'b1;
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic wait_idle();
    int k;
    k = 0;
    @(negedge clk);
    while (!(prog_ready && buf_empty) && k < 20000) begin @(negedge clk); k++; end
    check(k < 20000, "R12 completion", k, 0);
  endtask

  task automatic check_run(input logic [1:0] s, input logic [31:0] d, input logic [9:0] a,
                           input int ts, input int tw, input int tg, input int th, input int tr);
    int exp_bits[128];
    logic exp_arr[128];
    int ne;
    bit ok;
    ne = 0;
    if (s == 2'd0 || s == 2'd1)
      for (int i = 0; i < 32; i++) if (d[i]) begin exp_bits[ne] = i; exp_arr[ne] = 1'b0; ne++; end
    if (s == 2'd0 || s == 2'd2)
      for (int i = 0; i < 32; i++) if (d[i]) begin exp_bits[ne] = i; exp_arr[ne] = 1'b1; ne++; end
    check(n_p == ne, "R8 pulse count", n_p, ne);
    ok = (n_p == ne);
    for (int i = 0; i < ne && i < n_p; i++)
      if (bits_q[i] != exp_bits[i] || arr_q[i] != exp_arr[i]) ok = 1'b0;
    check(ok, "R5 pulse order and array", n_p, ne);
    if (ne > 0) begin
      check(addr_seen == a, "R5 prog_addr", addr_seen, a);
      check(setup_t == ts + 1, "R4 setup ticks", setup_t, ts + 1);
      check(w_min == tw + 1 && w_max == tw + 1, "R5 width ticks", w_max, tw + 1);
      if (ne > 1) check(g_min == tg + 1 && g_max == tg + 1, "R6 gap ticks", g_max, tg + 1);
      check(hold_t == th + 1, "R7 hold ticks", hold_t, th + 1);
    end else begin
      check(hold_t == ts + th + 2, "R10 enable ticks no pulses", hold_t, ts + th + 2);
    end
    check(recov_t == tr + 1, "R7 recovery ticks", recov_t, tr + 1);
    check(buf_data == d && buf_addr == a, "R1 buffer readback", buf_data, d);
  endtask

  // vectors: {sel[43:42], addr[41:32], data[31:0]}
  localparam logic [43:0] VEC [0:5] = '{
    {2'd1, 10'h005, 32'h0000_0013},
    {2'd2, 10'h3FF, 32'h8000_0001},
    {2'd0, 10'h100, 32'h0000_0A00},
    {2'd3, 10'h007, 32'hFFFF_FFFF},
    {2'd0, 10'h002, 32'h0000_0000},
    {2'd0, 10'h2AA, 32'hFFFF_FFFF}
  };

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    clear_mon();
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(buf_empty && prog_ready && !pgm_en && !pulse_norm && !pulse_red,
          "R3 reset state", {buf_empty, prog_ready, pgm_en, pulse_norm, pulse_red}, 5'b11000);

    // R2: no launch outside program mode
    write_word(32'h0000_00F0, 10'h0AB);
    repeat (4) @(negedge clk);
    check(buf_empty && prog_ready && !pgm_en, "R2 no launch", {buf_empty, prog_ready, pgm_en}, 3'b110);
    check(buf_addr == 10'h0AB, "R2 address stored", buf_addr, 10'h0AB);

    // table of vectors
    foreach (VEC[i]) begin
      enter_mode(VEC[i][43:42]);
      clear_mon();
      write_word(VEC[i][31:0], VEC[i][41:32]);
      wait_idle();
      check_run(VEC[i][43:42], VEC[i][31:0], VEC[i][41:32], 2, 3, 1, 2, 4);
    end

    // R3 / R1 / R12: flag timing, locked buffer, queued request
    enter_mode(2'd1);
    clear_mon();
    write_word(32'h0000_0003, 10'h001);
    @(negedge clk);
    check(!buf_empty && prog_ready, "R3 launch cycle", {buf_empty, prog_ready}, 2'b01);
    @(negedge clk);
    check(buf_empty && !prog_ready, "R3 captured", {buf_empty, prog_ready}, 2'b10);
    write_word(32'h0000_0004, 10'h002);
    write_word(32'h0000_DEAD, 10'h033);
    @(negedge clk);
    check(buf_data == 32'h4 && buf_addr == 10'h002 && !buf_empty, "R1 writes ignored while full",
          buf_data, 32'h4);
    wait_idle();
    check(n_p == 3 && bits_q[0] == 0 && bits_q[1] == 1 && bits_q[2] == 2 &&
          !arr_q[0] && !arr_q[2], "R12 queued request pulses", n_p, 3);

    // R9: select change without re-entry has no effect
    enter_mode(2'd1);
    @(posedge clk); #1 arr_sel = 2'd2;
    clear_mon();
    write_word(32'h0000_0001, 10'h003);
    wait_idle();
    check(n_p == 1 && !arr_q[0], "R9 select held", arr_q[0], 0);
    enter_mode(2'd2);
    clear_mon();
    write_word(32'h0000_0001, 10'h003);
    wait_idle();
    check(n_p == 1 && arr_q[0], "R9 select after re-entry", arr_q[0], 1);

    // R11: sparse ticks and one-tick minimum intervals
    tick_div = 3;
    t_setup = 5'd1; t_width = 5'd2; t_gap = 3'd0; t_hold = 5'd0; t_recov = 7'd0;
    enter_mode(2'd1);
    clear_mon();
    write_word(32'h0000_0005, 10'h0FE);
    wait_idle();
    check_run(2'd1, 32'h0000_0005, 10'h0FE, 1, 2, 0, 0, 0);
    check(n_p == 2, "R11 sparse tick run", n_p, 2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule